// File: doc/BRIEF.md
# Loopback Code Detector with Interrupt

This block watches a received serial bit stream, one bit per receive-clock cycle, for two in-band repeating codes. A stream that repeats `00001` without a break for a programmable number of cycles switches a network loopback status on. A stream that repeats `001` for the same number of cycles switches it off. While the status is on, a routing output tells the datapath to loop received data back toward the line. A local loopback request holds that routing off without touching the status.

Detection is armed by driving the remote, local and all-ones control requests high together for at least one cycle. After that the requests can be released and the search keeps running. A remote loopback request on its own, without both other requests, drops the status and disarms the search.

An active-low interrupt falls when the loopback status, the alarm-indication input or the loss-of-signal input changes. It stays low until the host pulses an acknowledge input. The hold time is the `HOLD` parameter, counted in cycles. About five seconds at 1.544 MHz is 7,720,000 cycles.

Top module: `lbcode_detector`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `nlb_status` and `nlb_route` are 0 and `irq_n` is 1.
- R2: A cycle qualifies for the activate code when the search is armed, the current bit equals the bit received 5 cycles earlier, and the current bit plus the 4 bits before it hold exactly one 1. After `HOLD` consecutive qualifying cycles, `nlb_status` is 1 from the next cycle on.
- R3: The release code qualifies in the same way with period 3: the current bit equals the bit 3 cycles earlier, and the current bit plus the 2 bits before it hold exactly one 1. `HOLD` consecutive qualifying cycles make `nlb_status` 0 from the next cycle on.
- R4: A single cycle that does not qualify restarts that code's count from zero. A run broken before `HOLD` cycles does not change `nlb_status`.
- R5: The search is armed at a clock edge where `remote_req`, `local_req` and `ones_req` are all 1. Until then, and after a release (R6), neither code changes `nlb_status`. Reset disarms the search. The bit history starts as all zeros.
- R6: At an edge where `remote_req` is 1 and `local_req` and `ones_req` are not both 1, `nlb_status` becomes 0 and the search is disarmed. This takes priority over a code match.
- R7: `nlb_route` is 1 exactly when `nlb_status` is 1 and `local_req` is 0. `local_req` alone never changes `nlb_status`.
- R8: If `nlb_status`, `ais_in` or `los_in` at an edge differs from its value at the previous edge, `irq_n` is 0 from the next cycle on. The alarm inputs are compared against the values they hold at the last reset edge.
- R9: Once low, `irq_n` stays low until an edge with `irq_ack` high and no new change (R8) in the same cycle. After that edge it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one received bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received data bit |
| remote_req | input | 1 | Remote loopback request |
| local_req | input | 1 | Local loopback request |
| ones_req | input | 1 | All-ones transmit request |
| ais_in | input | 1 | Alarm indication status to monitor |
| los_in | input | 1 | Loss-of-signal status to monitor |
| irq_ack | input | 1 | Host acknowledge, clears the pending interrupt |
| nlb_status | output | 1 | Network loopback status |
| nlb_route | output | 1 | Loopback routing enable, status gated by local request |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench targets a code run broken a few cycles short of `HOLD`. A design that failed to restart its count would switch the status early. It also sends the codes before arming, where a design that ignored the arm step would switch on. Another case raises local loopback while the status is on: a wrong design would drop the status instead of only the routing. An acknowledge that lands in the same cycle as an alarm change must leave the interrupt low, and a design that let the acknowledge win would lose that event. Random segments mix both codes, noise, control pulses and alarm toggles, and each cycle is compared with a cycle model of the requirements. Off-by-one errors in the hold count or the history taps show up as a status edge one cycle out of place.

// File: rtl/lbd_pkg.sv
// Shared definitions for the loopback code detector.
// Assumes: the control requests are already synchronous to the receive clock.
package lbd_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_ARM     = 2'd1,
        CMD_RELEASE = 2'd2
    } ctl_cmd_e;

    localparam int NUM_CODES = 2;
    localparam int IDX_ACT   = 0;
    localparam int IDX_REL   = 1;

    // Repeat period of each searched code: activate code first, release code second.
    function automatic int code_period(input int idx);
        return (idx == IDX_ACT) ? 5 : 3;
    endfunction

    // Turns the three control requests into one command; all three high arms the search.
    function automatic ctl_cmd_e decode_ctl(input logic remote, input logic local_lb,
                                            input logic ones);
        if (remote && local_lb && ones) return CMD_ARM;
        if (remote)                     return CMD_RELEASE;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/lbd_code_match.sv
// Searches for one repeating code of period PERIOD containing a single 1.
// A cycle qualifies when the bit matches the bit PERIOD cycles back and the
// last PERIOD bits hold exactly one 1. hit is high on the HOLD-th and every
// later consecutive qualifying cycle.
// Assumes: PERIOD >= 2, HOLD >= 1, one bit per clock.
module lbd_code_match #(
    parameter int PERIOD = 5,
    parameter int HOLD   = 7720000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_in,
    output logic hit
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [PERIOD-1:0] hist;
    logic [PERIOD-1:0] window;
    logic [CW-1:0]     cnt;
    logic              qual;

    assign window = {hist[PERIOD-2:0], bit_in};

    // Qualifies the current bit against the code shape and period.
    always_comb begin
        qual = run && (bit_in == hist[PERIOD-1]) && ($countones(window) == 1);
    end

    assign hit = qual && (cnt == LAST);

    // Keeps the last PERIOD received bits, newest in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[PERIOD-2:0], bit_in};
    end

    // Counts consecutive qualifying cycles, saturating at HOLD-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !qual) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/lbd_irq.sv
// Change-detect interrupt: any source differing from its value at the
// previous edge sets a pending flag; ack clears it unless a change coincides.
// Assumes: sources in FOLLOW_MASK are external and track their input during
// reset; the others reset to 0 together with their driver.
module lbd_irq #(
    parameter int NSRC = 3,
    parameter logic [NSRC-1:0] FOLLOW_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic            ack,
    output logic            irq_n
);
    logic [NSRC-1:0] prev;
    logic            pend;

    // Remembers every source at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= src & FOLLOW_MASK;
        else        prev <= src;
    end

    // Holds the interrupt until acknowledged; a new change wins over ack.
    always_ff @(posedge clk) begin
        if (!rst_n)              pend <= 1'b0;
        else if (|(src ^ prev))  pend <= 1'b1;
        else if (ack)            pend <= 1'b0;
    end

    assign irq_n = ~pend;

endmodule

// File: rtl/lbcode_detector.sv
// Loopback code detector top: arms on the combined control request, runs one
// matcher per code, keeps the loopback status and raises the interrupt.
// Assumes: rx_bit carries one received bit per clock; HOLD in clock cycles.
module lbcode_detector #(
    parameter int HOLD = 7720000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic remote_req,
    input  logic local_req,
    input  logic ones_req,
    input  logic ais_in,
    input  logic los_in,
    input  logic irq_ack,
    output logic nlb_status,
    output logic nlb_route,
    output logic irq_n
);
    import lbd_pkg::*;

    ctl_cmd_e               cmd;
    logic                   armed;
    logic [NUM_CODES-1:0]   hit;

    assign cmd = decode_ctl(remote_req, local_req, ones_req);

    // Arms the search on the combined request, disarms on a plain remote request.
    always_ff @(posedge clk) begin
        if (!rst_n)                  armed <= 1'b0;
        else if (cmd == CMD_RELEASE) armed <= 1'b0;
        else if (cmd == CMD_ARM)     armed <= 1'b1;
    end

    // One matcher per code.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        lbd_code_match #(
            .PERIOD(code_period(g)),
            .HOLD  (HOLD)
        ) u_match (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (armed),
            .bit_in(rx_bit),
            .hit   (hit[g])
        );
    end

    // Loopback status: release request first, then activate, then release code.
    always_ff @(posedge clk) begin
        if (!rst_n)                  nlb_status <= 1'b0;
        else if (cmd == CMD_RELEASE) nlb_status <= 1'b0;
        else if (hit[IDX_ACT])       nlb_status <= 1'b1;
        else if (hit[IDX_REL])       nlb_status <= 1'b0;
    end

    assign nlb_route = nlb_status && !local_req;

    lbd_irq #(
        .NSRC       (3),
        .FOLLOW_MASK(3'b110)
    ) u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .src  ({los_in, ais_in, nlb_status}),
        .ack  (irq_ack),
        .irq_n(irq_n)
    );

endmodule

// File: rtl/lbd_checker.sv
// Properties of the loopback code detector, bound to every instance of the top.
module lbd_checker (
    input logic clk,
    input logic rst_n,
    input logic remote_req,
    input logic local_req,
    input logic ones_req,
    input logic los_in,
    input logic irq_ack,
    input logic armed,
    input logic nlb_status,
    input logic nlb_route,
    input logic irq_n
);
    AST_ROUTE_OFF_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        local_req |-> !nlb_route);                                            // R7
    AST_ROUTE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !nlb_status |-> !nlb_route);                                          // R7
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_req && !(local_req && ones_req)) |=> !nlb_status);            // R6
    AST_NO_RISE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !$rose(nlb_status));                                       // R5
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !irq_ack) |=> !irq_n);                                     // R9
    AST_IRQ_ON_LOS: assert property (@(posedge clk) disable iff (!rst_n)
        (los_in != $past(los_in)) |=> !irq_n);                                // R8
    AST_IRQ_ON_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (nlb_status != $past(nlb_status))) |=> !irq_n);      // R8
endmodule

bind lbcode_detector lbd_checker u_lbd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .remote_req(remote_req),
    .local_req (local_req),
    .ones_req  (ones_req),
    .los_in    (los_in),
    .irq_ack   (irq_ack),
    .armed     (armed),
    .nlb_status(nlb_status),
    .nlb_route (nlb_route),
    .irq_n     (irq_n)
);

// File: tb/tb_lbcode_detector.sv
module tb_lbcode_detector;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0, remote_req = 1'b0, local_req = 1'b0, ones_req = 1'b0;
    logic ais_in = 1'b0, los_in = 1'b0, irq_ack = 1'b0;
    logic nlb_status, nlb_route, irq_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lbcode_detector #(.HOLD(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .remote_req(remote_req),
        .local_req(local_req), .ones_req(ones_req), .ais_in(ais_in),
        .los_in(los_in), .irq_ack(irq_ack), .nlb_status(nlb_status),
        .nlb_route(nlb_route), .irq_n(irq_n)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string tag   = "R1";
    bit    done  = 1'b0;

    // Requirement model state.
    logic [5:0] m_hist = '0;
    int  m_run_a = 0, m_run_b = 0;
    bit  m_arm = 0, m_stat = 0, m_pend = 0, p_ais = 0, p_los = 0, p_stat = 0;
    bit  e_rel, e_arm, e_chg, e_qa, e_qb;

    function automatic bit qualifies(logic [5:0] h, bit b, int p);
        int ones = int'(b);
        for (int i = 0; i < p - 1; i++) ones += int'(h[i]);
        return (b == h[p-1]) && (ones == 1);
    endfunction

    // Advances the model at every edge from the inputs seen there.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist = '0; m_run_a = 0; m_run_b = 0; m_arm = 0; m_stat = 0;
            m_pend = 0; p_ais = ais_in; p_los = los_in; p_stat = 0;
        end else begin
            e_rel = remote_req && !(local_req && ones_req);
            e_arm = remote_req && local_req && ones_req;
            e_chg = (ais_in != p_ais) || (los_in != p_los) || (m_stat != p_stat);
            p_ais = ais_in; p_los = los_in; p_stat = m_stat;
            if (e_chg) m_pend = 1;
            else if (irq_ack) m_pend = 0;
            e_qa = m_arm && qualifies(m_hist, rx_bit, 5);
            e_qb = m_arm && qualifies(m_hist, rx_bit, 3);
            m_run_a = e_qa ? m_run_a + 1 : 0;
            m_run_b = e_qb ? m_run_b + 1 : 0;
            if (e_rel) m_stat = 0;
            else if (e_qa && m_run_a >= HOLD) m_stat = 1;
            else if (e_qb && m_run_b >= HOLD) m_stat = 0;
            m_arm = e_rel ? 1'b0 : (e_arm ? 1'b1 : m_arm);
            m_hist = {m_hist[4:0], rx_bit};
        end
    end

    task automatic check(string req, string what, logic got, logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    // Compares outputs a quarter period after each edge.
    always @(posedge clk) begin
        #(CLK_PERIOD / 4);
        if (!done) begin
            check(tag, "nlb_status", nlb_status, m_stat);
            check(tag, "nlb_route", nlb_route, m_stat && !local_req);
            check(tag, "irq_n", irq_n, !m_pend);
        end
    end

    task automatic send(int period, int n, int flip_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_bit = ((i % period) == period - 1) ^ (i == flip_at);
        end
    endtask

    task automatic pulse_ctl(bit r, bit l, bit o);
        @(negedge clk);
        remote_req = r; local_req = l; ones_req = o;
        @(negedge clk);
        remote_req = 0; local_req = 0; ones_req = 0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        los_in = 1;                          // R8: held through reset, no event
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1";
        repeat (2) @(negedge clk);
        check("R1", "status after reset", nlb_status, 1'b0);
        check("R1", "irq_n after reset", irq_n, 1'b1);

        tag = "R5";                          // codes before arming
        send(5, 4 * HOLD, -1);
        check("R5", "status unarmed", nlb_status, 1'b0);

        pulse_ctl(1, 1, 1);
        tag = "R2";
        send(5, 3 * HOLD, -1);
        check("R2", "status after activate code", nlb_status, 1'b1);

        tag = "R9";
        ack();
        @(negedge clk);
        check("R9", "irq_n after ack", irq_n, 1'b1);

        tag = "R7";
        local_req = 1;
        send(3, 5, -1);
        check("R7", "status kept under local", nlb_status, 1'b1);
        check("R7", "route off under local", nlb_route, 1'b0);
        local_req = 0;

        tag = "R4";                          // broken release run
        send(3, HOLD + 2, HOLD - 3);
        check("R4", "status after broken run", nlb_status, 1'b1);

        tag = "R3";
        send(3, 2 * HOLD, -1);
        check("R3", "status after release code", nlb_status, 1'b0);

        tag = "R9";                          // change and ack in one cycle
        ack();
        @(negedge clk); ais_in = 1;
        @(negedge clk); ais_in = 0; irq_ack = 1;
        @(negedge clk); irq_ack = 0;
        check("R9", "irq_n kept when change meets ack", irq_n, 1'b0);

        tag = "R6";
        send(5, 2 * HOLD, -1);
        check("R6", "status before release request", nlb_status, 1'b1);
        pulse_ctl(1, 0, 0);
        send(5, 2 * HOLD, -1);
        check("R6", "status after release request", nlb_status, 1'b0);

        tag = "R8";                          // constrained random mix
        for (int seg = 0; seg < 300; seg++) begin
            int kind = int'($urandom_range(0, 3));
            int len  = int'($urandom_range(1, 3 * HOLD));
            int per  = (kind == 0) ? 5 : 3;
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                rx_bit     = (kind >= 2) ? 1'($urandom) : ((i % per) == per - 1);
                ais_in     = ($urandom_range(0, 29) == 0) ? ~ais_in : ais_in;
                los_in     = ($urandom_range(0, 29) == 0) ? ~los_in : los_in;
                irq_ack    = ($urandom_range(0, 9) == 0);
                local_req  = ($urandom_range(0, 15) == 0);
                remote_req = ($urandom_range(0, 199) == 0);
                ones_req   = local_req && ($urandom_range(0, 1) == 0);
                if ($urandom_range(0, 99) == 0) begin
                    remote_req = 1; local_req = 1; ones_req = 1;
                end
            end
        end
        @(negedge clk);
        remote_req = 0; local_req = 0; ones_req = 0; irq_ack = 0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog %s: got hang expected completion", tag);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule